// File: doc/BRIEF.md
# Status Word View Unit

This block keeps a processor's 32-bit status word, which is built from three fields: a set of condition flags, an execution-state field, and the number of the exception that is currently active. Software reads and writes the word through move-to-status and move-from-status requests. Each request carries a view selector and a privilege flag. The view selector chooses one field, a pair of fields, or the whole word. The block applies the read mask, the write mask and the privilege rule that belong to the chosen view. It then answers a read one cycle later. If the privilege rule is broken, it raises a one-cycle violation pulse.

The core's own hardware paths load the exception number and the execution state directly. Software can never change those two fields, and software never sees the execution-state bits. A separate output gives the full, unmasked status word, so the exception-entry logic can save the true execution state.

Top module: `stw_view_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, all three fields are zero, and `stk_word`, `rd_vld`, `rd_data` and `acc_viol` are zero.
- R2: A request with `req_vld`=1 and `req_wr`=0 raises `rd_vld` in the next cycle. `rd_data` then carries the current word masked by the view, and it is zero in every cycle without `rd_vld`. View codes: 0 = all fields, 1 = flags+exception, 2 = flags+execution state, 3 = exception+execution state, 4 = flags only, 5 = exception only, 6 = execution state only, 7 = empty view (reads zero).
- R3: A software read never returns a one in the execution-state positions (bits 26:24 and 15:10) in any view.
- R4: A privileged write in views 0, 1, 2 or 4 loads the flags from `req_wdata` bits 31:27 and 19:16, and the new flags are visible from the next cycle. Without such a write, the flags hold their value.
- R5: Software writes never change the exception number (bits 7:0) or the execution state. Writes in views 3, 5, 6 and 7 change nothing.
- R6: View 4 is open to both privilege levels. Any other view used with `req_priv`=0 reads zero and drops the write, and `acc_viol` is 1 in the next cycle for exactly that request. Privileged requests never raise `acc_viol`.
- R7: Bits 23:20 and 9:8 read as zero in `rd_data` and in `stk_word`.
- R8: `hw_exc_we` loads `hw_exc_num` into bits 7:0. `hw_est_we` loads `hw_est`, with bits 8:6 going to word bits 26:24 and bits 5:0 going to word bits 15:10. Both loads are visible from the next cycle.
- R9: `stk_word` always shows all three fields unmasked, including the execution state.
- R10: A hardware load and a software write in the same cycle both take effect. The flags come from software, and the exception and execution-state fields come from hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Software request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | View selector code |
| req_priv | input | 1 | 1 = privileged requester |
| req_wdata | input | 32 | Write data |
| hw_exc_we | input | 1 | Hardware load of the exception number |
| hw_exc_num | input | 8 | New exception number |
| hw_est_we | input | 1 | Hardware load of the execution state |
| hw_est | input | 9 | New execution state |
| rd_vld | output | 1 | Read response valid |
| rd_data | output | 32 | Masked read data |
| acc_viol | output | 1 | One-cycle privilege violation pulse |
| stk_word | output | 32 | Full unmasked status word |

## Verification
Every view is read at both privilege levels after hardware has set every execution-state bit. This separates masks that leak the execution state from masks that are correct, and it separates the privilege checks of the flags-only view from those of the other views. The write data covers all ones, all zeros and several mixed patterns spread over the four flag-writable views and the four non-writable views. A wrong write mask or a dropped reserved-bit guard shows up in the full word. One cycle combines a hardware load with a software write that also sets the exception bits, to confirm which source wins for each field.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned FLG_W  = 9;
  localparam int unsigned EST_W  = 9;
  localparam int unsigned EXC_W  = 8;
  localparam int unsigned VIEW_W = 3;

  localparam logic [WORD_W-1:0] FLG_MASK = 32'hF80F_0000;
  localparam logic [WORD_W-1:0] EST_MASK = 32'h0700_FC00;
  localparam logic [WORD_W-1:0] EXC_MASK = 32'h0000_00FF;
  localparam logic [WORD_W-1:0] RSV_MASK = ~(FLG_MASK | EST_MASK | EXC_MASK);

  typedef enum logic [VIEW_W-1:0] {
    VW_ALL     = 3'd0,
    VW_FLG_EXC = 3'd1,
    VW_FLG_EST = 3'd2,
    VW_EXC_EST = 3'd3,
    VW_FLG     = 3'd4,
    VW_EXC     = 3'd5,
    VW_EST     = 3'd6,
    VW_NONE    = 3'd7
  } view_e;

  typedef struct packed {
    logic flg_rd;
    logic exc_rd;
    logic flg_wr;
    logic need_priv;
  } view_attr_t;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [FLG_W-1:0] flg,
    input logic [EST_W-1:0] est,
    input logic [EXC_W-1:0] exc);
    return {flg[8:4], est[8:6], 4'b0000, flg[3:0], est[5:0], 2'b00, exc};
  endfunction

  function automatic logic [FLG_W-1:0] take_flags(input logic [WORD_W-1:0] w);
    return {w[31:27], w[19:16]};
  endfunction
endpackage

// File: rtl/stw_en_reg.sv
module stw_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/stw_view_decode.sv
module stw_view_decode
  import stw_pkg::*;
(
  input  logic [VIEW_W-1:0] view,
  output view_attr_t        attr
);
  always_comb begin
    attr = '{flg_rd: 1'b0, exc_rd: 1'b0, flg_wr: 1'b0, need_priv: 1'b1};
    unique case (view_e'(view))
      VW_ALL:     begin attr.flg_rd = 1'b1; attr.exc_rd = 1'b1; attr.flg_wr = 1'b1; end
      VW_FLG_EXC: begin attr.flg_rd = 1'b1; attr.exc_rd = 1'b1; attr.flg_wr = 1'b1; end
      VW_FLG_EST: begin attr.flg_rd = 1'b1; attr.flg_wr = 1'b1; end
      VW_EXC_EST: begin attr.exc_rd = 1'b1; end
      VW_FLG:     begin attr.flg_rd = 1'b1; attr.flg_wr = 1'b1; attr.need_priv = 1'b0; end
      VW_EXC:     begin attr.exc_rd = 1'b1; end
      VW_EST:     begin end
      VW_NONE:    begin end
      default:    begin end
    endcase
  end
endmodule

// File: rtl/stw_read_port.sv
module stw_read_port
  import stw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              viol_req,
  input  logic [WORD_W-1:0] rd_word,
  output logic              rd_vld,
  output logic [WORD_W-1:0] rd_data,
  output logic              acc_viol
);
  logic              vld_nxt;
  logic              viol_nxt;
  logic [WORD_W-1:0] data_nxt;

  always_comb begin
    vld_nxt  = rd_req;
    viol_nxt = viol_req;
    data_nxt = rd_req ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld   <= 1'b0;
      rd_data  <= '0;
      acc_viol <= 1'b0;
    end else begin
      rd_vld   <= vld_nxt;
      rd_data  <= data_nxt;
      acc_viol <= viol_nxt;
    end
  end
endmodule

// File: rtl/stw_view_unit.sv
module stw_view_unit
  import stw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [VIEW_W-1:0] req_view,
  input  logic              req_priv,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              hw_exc_we,
  input  logic [EXC_W-1:0]  hw_exc_num,
  input  logic              hw_est_we,
  input  logic [EST_W-1:0]  hw_est,
  output logic              rd_vld,
  output logic [WORD_W-1:0] rd_data,
  output logic              acc_viol,
  output logic [WORD_W-1:0] stk_word
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  view_attr_t        attr;
  logic              acc_ok;
  logic              viol_req;
  logic              rd_req;
  logic              flg_we;
  logic [WORD_W-1:0] rd_mask;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] rd_word;
  logic [FLG_W-1:0]  flg_q;
  logic [EST_W-1:0]  est_q;
  logic [EXC_W-1:0]  exc_q;

  stw_view_decode dec_i (
    .view (req_view),
    .attr (attr)
  );

  always_comb begin
    acc_ok   = req_vld && (req_priv || !attr.need_priv);
    viol_req = req_vld && !acc_ok;
    rd_req   = req_vld && !req_wr;
    flg_we   = acc_ok && req_wr && attr.flg_wr;
    rd_mask  = (attr.flg_rd ? FLG_MASK : '0) | (attr.exc_rd ? EXC_MASK : '0);
    cur_word = pack_word(flg_q, est_q, exc_q);
    rd_word  = acc_ok ? (cur_word & rd_mask) : '0;
  end

  stw_en_reg #(.W(FLG_W)) flg_reg_i (
    .clk (clk), .rst_n (rst_sync_n), .en (flg_we),
    .d (take_flags(req_wdata)), .q (flg_q)
  );
  stw_en_reg #(.W(EST_W)) est_reg_i (
    .clk (clk), .rst_n (rst_sync_n), .en (hw_est_we),
    .d (hw_est), .q (est_q)
  );
  stw_en_reg #(.W(EXC_W)) exc_reg_i (
    .clk (clk), .rst_n (rst_sync_n), .en (hw_exc_we),
    .d (hw_exc_num), .q (exc_q)
  );

  stw_read_port rdp_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .viol_req (viol_req),
    .rd_word  (rd_word),
    .rd_vld   (rd_vld),
    .rd_data  (rd_data),
    .acc_viol (acc_viol)
  );

  assign stk_word = cur_word;
endmodule

// File: rtl/stw_view_chk.sv
module stw_view_chk
  import stw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic              req_wr,
  input logic [VIEW_W-1:0] req_view,
  input logic              req_priv,
  input logic              hw_exc_we,
  input logic [EXC_W-1:0]  hw_exc_num,
  input logic              hw_est_we,
  input logic [EST_W-1:0]  hw_est,
  input logic              rd_vld,
  input logic [WORD_W-1:0] rd_data,
  input logic              acc_viol,
  input logic [WORD_W-1:0] stk_word
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr) |=> rd_vld); // R2
  AST_NO_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && !req_wr) |=> (!rd_vld && rd_data == '0)); // R2
  AST_EST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> ((rd_data & EST_MASK) == '0)); // R3
  AST_FLG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && req_wr) |=> ((stk_word & FLG_MASK) == $past(stk_word & FLG_MASK))); // R4
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_exc_we |=> (stk_word[7:0] == $past(stk_word[7:0]))); // R5
  AST_EST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_est_we |=> ((stk_word & EST_MASK) == $past(stk_word & EST_MASK))); // R5
  AST_VIOL_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_priv && req_view != 3'd4)
      |=> (acc_viol && (stk_word & FLG_MASK) == $past(stk_word & FLG_MASK))); // R6
  AST_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_vld || req_priv || req_view == 3'd4) |=> !acc_viol); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & RSV_MASK) == '0) && ((stk_word & RSV_MASK) == '0)); // R7
  AST_HW_EXC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hw_exc_we |=> (stk_word[7:0] == $past(hw_exc_num))); // R8
  AST_HW_EST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hw_est_we |=> ({stk_word[26:24], stk_word[15:10]} == $past(hw_est))); // R8
endmodule

bind stw_view_unit stw_view_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_vld    (req_vld),
  .req_wr     (req_wr),
  .req_view   (req_view),
  .req_priv   (req_priv),
  .hw_exc_we  (hw_exc_we),
  .hw_exc_num (hw_exc_num),
  .hw_est_we  (hw_est_we),
  .hw_est     (hw_est),
  .rd_vld     (rd_vld),
  .rd_data    (rd_data),
  .acc_viol   (acc_viol),
  .stk_word   (stk_word)
);

// File: tb/stw_view_unit_tb_top.sv
`timescale 1ns/1ps
module stw_view_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr, req_priv;
  logic [2:0]  req_view;
  logic [31:0] req_wdata;
  logic        hw_exc_we, hw_est_we;
  logic [7:0]  hw_exc_num;
  logic [8:0]  hw_est;
  logic        rd_vld, acc_viol;
  logic [31:0] rd_data, stk_word;

  stw_view_unit dut_i (
    .clk (clk), .rst_n (rst_n), .req_vld (req_vld), .req_wr (req_wr),
    .req_view (req_view), .req_priv (req_priv), .req_wdata (req_wdata),
    .hw_exc_we (hw_exc_we), .hw_exc_num (hw_exc_num),
    .hw_est_we (hw_est_we), .hw_est (hw_est),
    .rd_vld (rd_vld), .rd_data (rd_data), .acc_viol (acc_viol), .stk_word (stk_word)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          due;
    logic        vld;
    logic [31:0] data;
    logic        viol;
    string       tag;
  } exp_t;

  exp_t       sb_q[$];
  exp_t       got;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_err = 0;
  logic [8:0] m_flg = '0;
  logic [8:0] m_est = '0;
  logic [7:0] m_exc = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] m_word();
    return {m_flg[8:4], m_est[8:6], 4'h0, m_flg[3:0], m_est[5:0], 2'b00, m_exc};
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] v, input logic p);
    logic [31:0] msk;
    if (!p && v != 3'd4) return 32'h0;
    case (v)
      3'd0, 3'd1: msk = 32'hF80F_00FF;
      3'd2, 3'd4: msk = 32'hF80F_0000;
      3'd3, 3'd5: msk = 32'h0000_00FF;
      default:    msk = 32'h0;
    endcase
    return m_word() & msk;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      got = sb_q.pop_front();
      check({got.tag, " rd_vld"},   {31'h0, rd_vld},   {31'h0, got.vld});
      check({got.tag, " rd_data"},  rd_data,           got.data);
      check({got.tag, " acc_viol"}, {31'h0, acc_viol}, {31'h0, got.viol});
    end
  end

  task automatic step(input logic rv, input logic w, input logic [2:0] v, input logic p,
                      input logic [31:0] wd, input logic he, input logic [7:0] hv,
                      input logic se, input logic [8:0] sv, input string tag);
    exp_t e;
    @(negedge clk);
    req_vld = rv; req_wr = w; req_view = v; req_priv = p; req_wdata = wd;
    hw_exc_we = he; hw_exc_num = hv; hw_est_we = se; hw_est = sv;
    e.due  = cyc + 1;
    e.vld  = rv && !w;
    e.data = (rv && !w) ? m_read(v, p) : 32'h0;
    e.viol = rv && !p && (v != 3'd4);
    e.tag  = tag;
    sb_q.push_back(e);
    if (rv && w && (p || v == 3'd4) && (v == 3'd0 || v == 3'd1 || v == 3'd2 || v == 3'd4))
      m_flg = {wd[31:27], wd[19:16]};
    if (he) m_exc = hv;
    if (se) m_est = sv;
  endtask

  task automatic rd(input logic [2:0] v, input logic p, input string tag);
    step(1'b1, 1'b0, v, p, 32'h0, 1'b0, 8'h0, 1'b0, 9'h0, tag);
  endtask

  task automatic wr(input logic [2:0] v, input logic p, input logic [31:0] wd, input string tag);
    step(1'b1, 1'b1, v, p, wd, 1'b0, 8'h0, 1'b0, 9'h0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 0; req_wr = 0; req_view = 0; req_priv = 0; req_wdata = 0;
    hw_exc_we = 0; hw_exc_num = 0; hw_est_we = 0; hw_est = 0;
  endtask

  task automatic chk_stk(input string tag);
    idle();
    check({tag, " stk_word"}, stk_word, m_word());
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_vld = 0; req_wr = 0; req_view = 0; req_priv = 0; req_wdata = 0;
    hw_exc_we = 0; hw_exc_num = 0; hw_est_we = 0; hw_est = 0;
    repeat (3) @(negedge clk);
    check("R1 reset stk_word", stk_word, 32'h0);
    check("R1 reset outputs", {30'h0, rd_vld, acc_viol}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release stk_word", stk_word, 32'h0);
    check("R1 after release rd_data", rd_data, 32'h0);

    // R8 R9: hardware loads, full word shows execution state
    step(1'b0, 1'b0, 3'd0, 1'b0, 32'h0, 1'b1, 8'h2A, 1'b1, 9'h1FF, "R8 hw load");
    chk_stk("R8 R9 hw visible");

    // R2 R3: every view, privileged
    for (int v = 0; v < 8; v++) rd(3'(v), 1'b1, $sformatf("R2 R3 view%0d priv", v));
    idle();

    // R4 R7: all-ones flag write
    wr(3'd0, 1'b1, 32'hFFFF_FFFF, "R4 write all ones");
    chk_stk("R4 R5 R7 after all ones");
    rd(3'd0, 1'b1, "R7 read reserved zero");

    // R5: non-writable views
    wr(3'd3, 1'b1, 32'h0, "R5 write view3");
    wr(3'd5, 1'b1, 32'h0, "R5 write view5");
    wr(3'd6, 1'b1, 32'h0, "R5 write view6");
    wr(3'd7, 1'b1, 32'h0, "R5 write view7");
    chk_stk("R5 no change");

    wr(3'd1, 1'b1, 32'h0005_0000, "R4 write view1");
    rd(3'd4, 1'b1, "R4 read view4");
    wr(3'd2, 1'b1, 32'hA800_0000, "R4 write view2");
    rd(3'd2, 1'b1, "R4 read view2");

    // R6: privilege rules
    wr(3'd0, 1'b0, 32'h0, "R6 unpriv write view0");
    rd(3'd1, 1'b0, "R6 unpriv read view1");
    rd(3'd4, 1'b0, "R6 unpriv read view4");
    wr(3'd4, 1'b0, 32'h5003_0000, "R6 unpriv write view4");
    rd(3'd0, 1'b1, "R6 readback");
    for (int v = 0; v < 8; v++) rd(3'(v), 1'b0, $sformatf("R6 view%0d unpriv", v));
    chk_stk("R6 state");

    // R10: hardware and software in the same cycle
    step(1'b1, 1'b1, 3'd0, 1'b1, 32'h7000_00FF, 1'b1, 8'h11, 1'b1, 9'h0A5, "R10 combined");
    chk_stk("R10 combined result");
    rd(3'd0, 1'b1, "R10 readback");

    // R4 R2: mixed patterns over flag-writable views
    for (int i = 0; i < 8; i++) begin
      logic [2:0] vw;
      case (i % 4)
        0: vw = 3'd0;
        1: vw = 3'd1;
        2: vw = 3'd2;
        default: vw = 3'd4;
      endcase
      wr(vw, 1'b1, 32'h2468_ACE1 * (i + 1), $sformatf("R4 pattern %0d", i));
      rd(3'd0, 1'b1, $sformatf("R2 pattern %0d read", i));
    end
    chk_stk("R9 final");
    idle();
    idle();
    finish_run();
  end
endmodule